// File: doc/BRIEF.md
# Bit-Plane Parallel Distributed-Arithmetic DCT Coefficient Engine

This block computes one output coefficient of a one-dimensional DCT as the inner product of four signed input samples with four fixed weights, W0 to W3, taken from one row of the transform matrix. The four samples are already combined by a butterfly stage, so each one is 13 bits wide. The engine does not use multipliers. It cuts the samples into 13 bit planes and gives each plane its own lookup-and-shift unit. The partial results of all planes are added in one clock cycle. A constant offset is then applied, and the sum is rounded and saturated into a 12-bit signed coefficient.

Each lookup unit uses offset-binary coding. The first sample's bit decides two things: whether the other three address bits are inverted and whether the word read is negated. Because of this folding, an 8-word table is enough where 16 words would otherwise be needed. A precision-mode pin makes the engine use table words whose low four bits are cleared. This trades coefficient accuracy for fewer switching bits. The mode applies to each sample on its own.

The datapath from the samples to the rounded value is combinational. With the default setting, one output register captures the result whenever a valid sample is presented.

Top module: `da_dct_pe`

## Requirements
- R1: While reset is held and in the first cycle after it, `coefOut` is 0 and `coefValid` is 0.
- R2: With the output register enabled, every clock edge at which `inValid` is 1 produces exactly one result. The result appears on `coefOut` with `coefValid` = 1 after that edge. `coefValid` is 0 after an edge at which `inValid` is 0.
- R3: With `precMode` = 0, the result equals sat(floor(y / 2^11 + 1/2)), where y = W0·sampleA + W1·sampleB + W2·sampleC + W3·sampleD and the samples are read as two's-complement 13-bit values.
- R4: A value of y / 2^11 that lies exactly halfway between two integers rounds toward plus infinity. With the default weights, sampleA = 256 gives 126 and sampleA = −256 gives −125 (all other samples 0).
- R5: Results above 2047 are output as 2047 (0x7FF), and results below −2048 are output as −2048 (0x800).
- R6: With `precMode` = 1, the weighted sum is built plane by plane. Plane k takes bit (12−k) of each sample. Let b1 be the bit of sampleA in that plane. The table word is R = W0 + Σj sj·Wj over the other three samples, where sj = +1 if that sample's bit equals b1 and −1 otherwise. R is then cleared in its low 4 bits, giving T. The plane value is Q = T if b1 = 1 and −T if b1 = 0. Then acc = Σ(k=1..12) 2^(12−k)·Qk − 2^12·Q0 − (W0+W1+W2+W3). The result is sat(floor((acc + 2^11) / 2^12)).
- R7: When `inValid` is 0, changes on the samples and on `precMode` do not alter `coefOut`. It keeps the last captured result.
- R8: `precMode` is sampled together with each sample, so samples with alternating modes presented on back-to-back cycles each get their own mode's result.
- R9: In full-precision mode, all-zero samples give a result of exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Samples and mode are valid this cycle |
| precMode | input | 1 | 0 = full-width table words, 1 = truncated table words |
| sampleA | input | 13 | First butterfly sample (weight W0), signed |
| sampleB | input | 13 | Second butterfly sample (weight W1), signed |
| sampleC | input | 13 | Third butterfly sample (weight W2), signed |
| sampleD | input | 13 | Fourth butterfly sample (weight W3), signed |
| coefOut | output | 12 | Rounded, saturated coefficient, signed |
| coefValid | output | 1 | coefOut holds a new result |

## Verification
The assertions cover four properties on every cycle:
- the one-cycle lag between `inValid` and `coefValid`,
- that the output register holds on idle cycles,
- that zero samples give a zero coefficient in full mode,
- that in truncated mode every plane contribution is a multiple of sixteen.

Some behaviours only the bench's scenarios can show. These are the numeric correctness of the folded tables against a direct product, the round-half-up ties, saturation at both limits, the exact truncated-mode value, and the per-sample mode switch. The bench checks them against two independent models: a direct multiply for full mode and a plane-by-plane evaluation of the truncated-mode formula.

// File: rtl/da_dct_pkg.sv
package da_dct_pkg;
  typedef struct packed {
    logic truncEn;
    logic capture;
  } peStrobes_t;
endpackage

// File: rtl/dape_rom_shift.sv
module dape_rom_shift #(
  parameter int IN_W       = 13,
  parameter int ROM_W      = 15,
  parameter int ACC_W      = 30,
  parameter int PLANE      = 0,
  parameter int TRUNC_BITS = 4,
  parameter int W0 = 0,
  parameter int W1 = 0,
  parameter int W2 = 0,
  parameter int W3 = 0
) (
  input  logic [3:0]              planeBits,
  input  logic                    truncEn,
  output logic signed [ACC_W-1:0] term
);
  localparam int SHIFT = IN_W - 1 - PLANE;
  localparam logic [ROM_W-1:0] LOW_MASK = ROM_W'((1 << TRUNC_BITS) - 1);

  function automatic logic signed [ROM_W-1:0] romEntry(input logic [2:0] addr);
    int s;
    s = W0 + (addr[0] ? W1 : -W1) + (addr[1] ? W2 : -W2) + (addr[2] ? W3 : -W3);
    return ROM_W'(s);
  endfunction

  logic [2:0]              romAddr;
  logic signed [ROM_W-1:0] rawWord;
  logic signed [ROM_W-1:0] usedWord;
  logic signed [ROM_W-1:0] signedWord;
  logic signed [ACC_W-1:0] scaled;

  always_comb begin
    romAddr    = ~(planeBits[3:1] ^ {3{planeBits[0]}});
    rawWord    = romEntry(romAddr);
    usedWord   = truncEn ? (rawWord & ~LOW_MASK) : rawWord;
    signedWord = planeBits[0] ? usedWord : -usedWord;
    scaled     = ACC_W'(signedWord) <<< SHIFT;
  end

  generate
    if (PLANE == 0) begin : g_signPlane
      assign term = -scaled;
    end else begin : g_magPlane
      assign term = scaled;
    end
  endgenerate
endmodule

// File: rtl/dape_ctrl.sv
module dape_ctrl
  import da_dct_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       precMode,
  output peStrobes_t st,
  output logic       coefValid
);
  always_comb begin
    st.truncEn = precMode;
    st.capture = inValid;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) coefValid <= 1'b0;
        else       coefValid <= inValid;
      end

      AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> coefValid); // R2
      AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !coefValid); // R2
    end else begin : g_comb
      assign coefValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/dape_datapath.sv
module dape_datapath
  import da_dct_pkg::*;
#(
  parameter int IN_W       = 13,
  parameter int OUT_W      = 12,
  parameter int COEF_W     = 12,
  parameter int FRAC       = 11,
  parameter int TRUNC_BITS = 4,
  parameter bit OUT_REG    = 1'b1,
  parameter int W0 = 1004,
  parameter int W1 = 851,
  parameter int W2 = 569,
  parameter int W3 = 200
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  peStrobes_t              st,
  input  logic signed [IN_W-1:0]  x1,
  input  logic signed [IN_W-1:0]  x2,
  input  logic signed [IN_W-1:0]  x3,
  input  logic signed [IN_W-1:0]  x4,
  output logic [OUT_W-1:0]        coefOut
);
  localparam int ROM_W = COEF_W + 3;
  localparam int ACC_W = IN_W + ROM_W + 2;
  localparam int SUM_W = W0 + W1 + W2 + W3;
  localparam logic signed [ACC_W-1:0] INIT_TERM = ACC_W'(SUM_W);
  localparam logic signed [ACC_W-1:0] RND_TERM  = ACC_W'(1) <<< FRAC;
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [ACC_W-1:0] terms [IN_W];
  logic signed [ACC_W-1:0] planeSum;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] rounded;
  logic [OUT_W-1:0]        coefNext;

  generate
    for (genvar k = 0; k < IN_W; k++) begin : g_plane
      dape_rom_shift #(
        .IN_W(IN_W), .ROM_W(ROM_W), .ACC_W(ACC_W), .PLANE(k),
        .TRUNC_BITS(TRUNC_BITS), .W0(W0), .W1(W1), .W2(W2), .W3(W3)
      ) u_unit (
        .planeBits({x4[IN_W-1-k], x3[IN_W-1-k], x2[IN_W-1-k], x1[IN_W-1-k]}),
        .truncEn(st.truncEn),
        .term(terms[k])
      );
    end
  endgenerate

  always_comb begin
    planeSum = '0;
    for (int k = 0; k < IN_W; k++) planeSum = planeSum + terms[k];
    acc     = planeSum - INIT_TERM;
    rounded = (acc + RND_TERM) >>> (FRAC + 1);
    if (rounded > MAXV)      coefNext = MAXV[OUT_W-1:0];
    else if (rounded < MINV) coefNext = MINV[OUT_W-1:0];
    else                     coefNext = rounded[OUT_W-1:0];
  end

  AST_TRUNC_GRAIN: assert property (@(posedge clk) disable iff (!rstN)
    st.truncEn |-> (planeSum[TRUNC_BITS-1:0] == '0)); // R6

  generate
    if (OUT_REG) begin : g_outReg
      always_ff @(posedge clk) begin
        if (!rstN)           coefOut <= '0;
        else if (st.capture) coefOut <= coefNext;
      end

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
        !st.capture |=> $stable(coefOut)); // R7
      AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rstN)
        (st.capture && !st.truncEn && x1 == '0 && x2 == '0 && x3 == '0 && x4 == '0)
        |=> (coefOut == '0)); // R9
    end else begin : g_outComb
      assign coefOut = coefNext;
    end
  endgenerate
endmodule

// File: rtl/da_dct_pe.sv
module da_dct_pe
  import da_dct_pkg::*;
#(
  parameter int IN_W       = 13,
  parameter int OUT_W      = 12,
  parameter int COEF_W     = 12,
  parameter int FRAC       = 11,
  parameter int TRUNC_BITS = 4,
  parameter bit OUT_REG    = 1'b1,
  parameter int WEIGHT0 = 1004,
  parameter int WEIGHT1 = 851,
  parameter int WEIGHT2 = 569,
  parameter int WEIGHT3 = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             precMode,
  input  logic [IN_W-1:0]  sampleA,
  input  logic [IN_W-1:0]  sampleB,
  input  logic [IN_W-1:0]  sampleC,
  input  logic [IN_W-1:0]  sampleD,
  output logic [OUT_W-1:0] coefOut,
  output logic             coefValid
);
  peStrobes_t strobes;

  dape_ctrl #(.OUT_REG(OUT_REG)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .precMode(precMode),
    .st(strobes), .coefValid(coefValid)
  );

  dape_datapath #(
    .IN_W(IN_W), .OUT_W(OUT_W), .COEF_W(COEF_W), .FRAC(FRAC),
    .TRUNC_BITS(TRUNC_BITS), .OUT_REG(OUT_REG),
    .W0(WEIGHT0), .W1(WEIGHT1), .W2(WEIGHT2), .W3(WEIGHT3)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(strobes),
    .x1($signed(sampleA)), .x2($signed(sampleB)),
    .x3($signed(sampleC)), .x4($signed(sampleD)),
    .coefOut(coefOut)
  );
endmodule

// File: tb/da_dct_pe_tb_top.sv
module da_dct_pe_tb_top;
  localparam int W0 = 1004, W1 = 851, W2 = 569, W3 = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        precMode = 1'b0;
  logic [12:0] sA = '0, sB = '0, sC = '0, sD = '0;
  logic [11:0] coefOut;
  logic        coefValid;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  string tagQ[$];
  int lastExp = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2 clk = ~clk;

  da_dct_pe dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .precMode(precMode),
    .sampleA(sA), .sampleB(sB), .sampleC(sC), .sampleD(sD),
    .coefOut(coefOut), .coefValid(coefValid)
  );

  function automatic int satRound(longint acc2);
    longint r;
    r = (acc2 + 2048) >>> 12;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  function automatic int fullModel(logic [12:0] a, logic [12:0] b, logic [12:0] c, logic [12:0] d);
    longint y;
    y = longint'(W0) * $signed(a) + longint'(W1) * $signed(b)
      + longint'(W2) * $signed(c) + longint'(W3) * $signed(d);
    return satRound(2 * y);
  endfunction

  function automatic int truncModel(logic [12:0] a, logic [12:0] b, logic [12:0] c, logic [12:0] d);
    longint acc = 0;
    for (int k = 0; k < 13; k++) begin
      int p, rw, tw, qv;
      p  = 12 - k;
      rw = W0 + ((b[p] == a[p]) ? W1 : -W1) + ((c[p] == a[p]) ? W2 : -W2)
              + ((d[p] == a[p]) ? W3 : -W3);
      tw = rw & ~15;
      qv = a[p] ? tw : -tw;
      if (k == 0) acc -= longint'(qv) * 4096;
      else        acc += longint'(qv) * (longint'(1) << p);
    end
    acc -= (W0 + W1 + W2 + W3);
    return satRound(acc);
  endfunction

  function automatic int toInt12(logic [11:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(logic [12:0] a, logic [12:0] b, logic [12:0] c, logic [12:0] d,
                      bit mode, string tag);
    int e;
    @(negedge clk);
    sA = a; sB = b; sC = c; sD = d; precMode = mode; inValid = 1'b1;
    e = mode ? truncModel(a, b, c, d) : fullModel(a, b, c, d);
    expQ.push_back(e);
    tagQ.push_back(tag);
    lastExp = e;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sA = lfsr[12:0]; sB = lfsr[25:13]; sC = ~lfsr[12:0]; sD = lfsr[31:19];
      precMode = lfsr[5];
    end
  endtask

  // Monitor: pops one expectation per valid result
  always @(negedge clk) begin
    if (rstN && !done && coefValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=unexpected valid expected=no result");
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, toInt12(coefOut), e);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 coefOut in reset", toInt12(coefOut), 0);
    check("R1 coefValid in reset", int'(coefValid), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 coefOut after reset", toInt12(coefOut), 0);
    check("R1 coefValid after reset", int'(coefValid), 0);

    send(13'd0, 13'd0, 13'd0, 13'd0, 1'b0, "R9 zero input");
    send(13'd100, 13'd0, 13'd0, 13'd0, 1'b0, "R3 single sample");
    send(13'd1000, -13'sd500, 13'd250, -13'sd125, 1'b0, "R3 mixed signs");
    send(13'd256, 13'd0, 13'd0, 13'd0, 1'b0, "R4 positive tie");
    send(-13'sd256, 13'd0, 13'd0, 13'd0, 1'b0, "R4 negative tie");
    send(13'h0FFF, 13'h0FFF, 13'h0FFF, 13'h0FFF, 1'b0, "R5 upper saturation");
    send(13'h1000, 13'h1000, 13'h1000, 13'h1000, 1'b0, "R5 lower saturation");
    send(13'd0, 13'd0, 13'd0, 13'd0, 1'b1, "R6 zero truncated");
    send(13'd777, -13'sd333, 13'd55, 13'd1234, 1'b1, "R6 mixed truncated");
    idle(1);
    @(negedge clk);
    check("R2 no valid after idle", int'(coefValid), 0);

    send(13'd1000, 13'd37, -13'sd700, 13'd5, 1'b0, "R7 capture before idle");
    idle(4);
    @(negedge clk);
    check("R7 hold while idle", toInt12(coefOut), lastExp);
    check("R7 valid low while idle", int'(coefValid), 0);

    for (int i = 0; i < 8; i++)
      send(13'd900 + 13'(i * 37), -13'sd411, 13'd17, 13'(i * 5), 1'(i % 2), "R8 alternating mode");

    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(lfsr[12:0], lfsr[25:13], {lfsr[3:0], lfsr[31:23]}, lfsr[18:6], lfsr[7],
           lfsr[7] ? "R6 random truncated" : "R3 random full");
      if (lfsr[9]) idle(1);
    end
    idle(3);
    check("R2 all results delivered", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule